// File: doc/BRIEF.md
# Cycle Tick Timer with Run Modes

This block is a per-core tick timer. It counts clock cycles in a count register and compares the low part of that count against a period held in a mode register. When the two are equal, the timer restarts from zero, stops and holds, or keeps counting, according to the selected run mode. If interrupts are enabled, the match also latches a sticky pending flag.

Software reaches both registers through a simple write-strobe and read-data port pair. The request line to the core is the pending flag gated by the timer-exception-enable bit of the core's status register. Software acknowledges an interrupt by writing the pending bit as 0. Nothing in the design can set the pending bit from a write.

The register width is `PERIOD_W + 4`. The mode register is laid out from the top bit down as a 2-bit run mode, the interrupt enable, the pending flag, and then a `PERIOD_W`-bit period.

Top module: `tick_timer`

## Requirements
- R1: After reset, the count register and the mode register both read 0 and `irq` is low.
- R2: The mode register layout is as follows. The run mode is in bits [W-1:W-2], where W = PERIOD_W+4: 00 is disabled, 01 is auto-restart, 10 is single-shot and 11 is continuous. Interrupt enable is bit PERIOD_W+1, pending is bit PERIOD_W, and the period is bits [PERIOD_W-1:0]. A write to the mode register reads back with these fields.
- R3: While the run mode is disabled, the count register does not change unless software writes it.
- R4: In auto-restart mode, a match (count bits [PERIOD_W-1:0] equal to the period) clears the count on the next edge, giving a cycle of period+1 clocks.
- R5: In single-shot mode, a match leaves the count frozen at the period value and counting stops.
- R6: In continuous mode, a match does not disturb counting. The full-width count keeps incrementing past the compare space, and only its low PERIOD_W bits are compared.
- R7: A match while the interrupt enable is set makes the pending bit read 1 from the next edge on. The bit stays set until software clears it.
- R8: A mode-register write with the pending bit as 1 does not set it. A write with the pending bit as 0 clears it.
- R9: `irq` is high exactly when the pending bit is set and `tee` is high.
- R10: Counting is halted when continuous mode is written while the count's low bits already equal the new period.
- R11: A count-register write loads the value on the next edge, and counting continues from it in a running mode.
- R12: In disabled mode, if the count equals the period while the interrupt enable is set, the pending bit is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cnt_we | input | 1 | Count-register write strobe |
| cnt_wdata | input | PERIOD_W+4 | Count-register write value |
| mode_we | input | 1 | Mode-register write strobe |
| mode_wdata | input | PERIOD_W+4 | Mode-register write value |
| tee | input | 1 | Timer-exception enable from the status register |
| cnt_rdata | output | PERIOD_W+4 | Current count |
| mode_rdata | output | PERIOD_W+4 | Current mode register |
| irq | output | 1 | Timer interrupt request |

## Verification
The bench builds the timer with `PERIOD_W = 8`, which gives a 12-bit register. At that size, the count can step over a 256-value compare space within a few cycles of a preloaded value. This lets the continuous-mode test observe a match on the low bits while the upper count bits keep climbing. Short periods of 2 to 9 make the restart cycle, the single-shot freeze and the disabled-mode match reachable in a handful of edges.

// File: rtl/tick_timer.sv
module tick_timer #(
  parameter int PERIOD_W = 28
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cnt_we,
  input  logic [PERIOD_W+3:0] cnt_wdata,
  input  logic                mode_we,
  input  logic [PERIOD_W+3:0] mode_wdata,
  input  logic                tee,
  output logic [PERIOD_W+3:0] cnt_rdata,
  output logic [PERIOD_W+3:0] mode_rdata,
  output logic                irq
);
  localparam int W      = PERIOD_W + 4;
  localparam int IE_BIT = PERIOD_W + 1;
  localparam int IP_BIT = PERIOD_W;

  localparam logic [1:0] M_OFF  = 2'b00;
  localparam logic [1:0] M_AUTO = 2'b01;
  localparam logic [1:0] M_ONCE = 2'b10;
  localparam logic [1:0] M_FREE = 2'b11;

  logic [W-1:0]        cnt;
  logic [1:0]          mode;
  logic                ie, ip, running;
  logic [PERIOD_W-1:0] period;
  logic                match, hit;

  assign match = cnt[PERIOD_W-1:0] == period;
  assign hit   = ie && match && (running || mode == M_OFF);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (cnt_we) begin
      cnt <= cnt_wdata;
    end else if (running) begin
      if (match && mode == M_AUTO)      cnt <= '0;
      else if (match && mode == M_ONCE) cnt <= W'(period);
      else                              cnt <= cnt + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode    <= M_OFF;
      ie      <= 1'b0;
      period  <= '0;
      running <= 1'b0;
    end else if (mode_we) begin
      mode    <= mode_wdata[W-1:W-2];
      ie      <= mode_wdata[IE_BIT];
      period  <= mode_wdata[PERIOD_W-1:0];
      running <= (mode_wdata[W-1:W-2] != M_OFF) &&
                 !(mode_wdata[W-1:W-2] == M_FREE &&
                   cnt[PERIOD_W-1:0] == mode_wdata[PERIOD_W-1:0]);
    end else if (running && match && mode == M_ONCE) begin
      running <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) ip <= 1'b0;
    else        ip <= (mode_we ? (ip & mode_wdata[IP_BIT]) : ip) | hit;
  end

  assign cnt_rdata  = cnt;
  assign mode_rdata = {mode, ie, ip, period};
  assign irq        = ip & tee;
endmodule

// File: rtl/tick_timer_chk.sv
module tick_timer_chk #(
  parameter int PERIOD_W = 28
) (
  input logic                clk,
  input logic                rst_n,
  input logic                cnt_we,
  input logic                mode_we,
  input logic [PERIOD_W+3:0] cnt_rdata,
  input logic [PERIOD_W+3:0] mode_rdata,
  input logic                tee,
  input logic                irq
);
  localparam int W = PERIOD_W + 4;
  logic [1:0] md;
  logic       ie, ip, eq;
  assign md = mode_rdata[W-1:W-2];
  assign ie = mode_rdata[PERIOD_W+1];
  assign ip = mode_rdata[PERIOD_W];
  assign eq = cnt_rdata[PERIOD_W-1:0] == mode_rdata[PERIOD_W-1:0];

  a_r9_irq_needs_tee: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (tee && ip));
  a_r9_irq_when_pending: assert property (@(posedge clk) disable iff (!rst_n)
    (ip && tee) |-> irq);
  a_r7_pending_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (ip && !mode_we) |=> ip);
  a_r7_pending_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ip) |-> $past(ie));
  a_r3_disabled_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (md == 2'b00 && !cnt_we) |=> $stable(cnt_rdata));
  a_r4_restart_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (md == 2'b01 && eq && !cnt_we) |=> (cnt_rdata == '0));
endmodule

bind tick_timer tick_timer_chk #(.PERIOD_W(PERIOD_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cnt_we(cnt_we), .mode_we(mode_we),
  .cnt_rdata(cnt_rdata), .mode_rdata(mode_rdata), .tee(tee), .irq(irq)
);

// File: tb/tick_timer_test.sv
module tick_timer_test;
  localparam int PW     = 8;
  localparam int W      = PW + 4;
  localparam int CLK_NS = 10;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         cnt_we = 1'b0, mode_we = 1'b0, tee = 1'b0;
  logic [W-1:0] cnt_wdata = '0, mode_wdata = '0;
  logic [W-1:0] cnt_rdata, mode_rdata;
  logic         irq;
  int checks = 0, fails = 0;

  always #(CLK_NS/2) clk = ~clk;

  tick_timer #(.PERIOD_W(PW)) uut (
    .clk(clk), .rst_n(rst_n), .cnt_we(cnt_we), .cnt_wdata(cnt_wdata),
    .mode_we(mode_we), .mode_wdata(mode_wdata), .tee(tee),
    .cnt_rdata(cnt_rdata), .mode_rdata(mode_rdata), .irq(irq)
  );

  task automatic check(string req, logic [W-1:0] act, logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic edges(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr_mode(logic [1:0] m, logic ie, logic ip, logic [PW-1:0] per);
    mode_wdata = {m, ie, ip, per};
    mode_we = 1'b1;
    @(negedge clk);
    mode_we = 1'b0;
  endtask

  task automatic wr_cnt(logic [W-1:0] v);
    cnt_wdata = v;
    cnt_we = 1'b1;
    @(negedge clk);
    cnt_we = 1'b0;
  endtask

  function automatic logic pend();
    return mode_rdata[PW];
  endfunction

  task automatic t_reset;
    check("R1 count", cnt_rdata, '0);
    check("R1 mode", mode_rdata, '0);
    check("R1 irq", W'(irq), '0);
  endtask

  task automatic t_disabled;
    wr_cnt(12'd5);
    edges(6);
    check("R3 count held", cnt_rdata, 12'd5);
    check("R12 no pend without enable", W'(pend()), '0);
  endtask

  task automatic t_restart;
    wr_cnt('0);
    wr_mode(2'b01, 1'b1, 1'b0, 8'd4);
    check("R2 readback", mode_rdata, {2'b01, 1'b1, 1'b0, 8'd4});
    edges(4);
    check("R4 reaches period", cnt_rdata, 12'd4);
    check("R7 not yet pending", W'(pend()), '0);
    edges(1);
    check("R4 cleared", cnt_rdata, 12'd0);
    check("R7 pending", W'(pend()), 12'd1);
    edges(2);
    check("R4 resumes", cnt_rdata, 12'd2);
    tee = 1'b0; #1;
    check("R9 gated", W'(irq), '0);
    tee = 1'b1; #1;
    check("R9 raised", W'(irq), 12'd1);
  endtask

  task automatic t_pending_write;
    wr_mode(2'b00, 1'b0, 1'b1, 8'd200);
    check("R8 write 1 keeps set", W'(pend()), 12'd1);
    wr_mode(2'b00, 1'b0, 1'b0, 8'd200);
    check("R8 write 0 clears", W'(pend()), '0);
    #1 check("R9 drops", W'(irq), '0);
    wr_mode(2'b00, 1'b0, 1'b1, 8'd200);
    check("R8 write 1 ignored", W'(pend()), '0);
  endtask

  task automatic t_single;
    wr_cnt('0);
    wr_mode(2'b10, 1'b1, 1'b0, 8'd3);
    edges(10);
    check("R5 frozen", cnt_rdata, 12'd3);
    check("R7 single pend", W'(pend()), 12'd1);
    edges(3);
    check("R5 still frozen", cnt_rdata, 12'd3);
  endtask

  task automatic t_continuous;
    wr_mode(2'b00, 1'b0, 1'b0, 8'd0);
    wr_cnt(12'd250);
    wr_mode(2'b11, 1'b1, 1'b0, 8'd2);
    edges(10);
    check("R6 keeps counting", cnt_rdata, 12'd260);
    check("R6 low-bit match pend", W'(pend()), 12'd1);
    wr_cnt(12'd100);
    check("R11 loaded", cnt_rdata, 12'd100);
    edges(3);
    check("R11 continues", cnt_rdata, 12'd103);
  endtask

  task automatic t_halt;
    wr_mode(2'b00, 1'b0, 1'b0, 8'd0);
    wr_cnt(12'd7);
    wr_mode(2'b11, 1'b0, 1'b0, 8'd7);
    edges(5);
    check("R10 halted", cnt_rdata, 12'd7);
  endtask

  task automatic t_disabled_match;
    wr_mode(2'b00, 1'b1, 1'b0, 8'd9);
    check("R12 before", W'(pend()), '0);
    wr_cnt(12'd9);
    edges(1);
    check("R12 pend set", W'(pend()), 12'd1);
    check("R3 held at 9", cnt_rdata, 12'd9);
  endtask

  initial begin
    fork
      begin
        edges(3);
        rst_n = 1'b1;
        edges(1);
        t_reset();
        t_disabled();
        t_restart();
        t_pending_write();
        t_single();
        t_continuous();
        t_halt();
        t_disabled_match();
      end
      begin
        repeat (5000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog expired");
      end
    join_any
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule